// File: doc/BRIEF.md
# Interrupt Status and Mask Register Bank

This block collects single-cycle event pulses from a serial peripheral into sticky status bits and turns them into one level-sensitive interrupt line. Software sees four registers that all use the same ten-bit layout: a status register, a read-only mask register, and a pair of write-only registers that either unmask or mask sources. The mask is never written directly. Each bit changes only when a one is written to the matching bit of the unmask or mask register. Status bits are cleared by writing ones back to them.

The bus side is a plain register port: byte address, write strobe, write data, and combinational read data. Decoded offsets are status 0x10, mask 0x20, unmask 0x24 and mask-set 0x28. The interrupt line is high whenever any status bit is set and its mask bit is clear. Bit meanings in every register: 0 completion, 1 data, 2 not-acknowledged, 3 timeout, 4 target ready, 5 receive overflow, 6 transmit overflow, 7 receive underflow, 8 unused, 9 arbitration lost.

Top module: `irq_regbank`

## Requirements
- R1: After synchronous reset, status reads 0x000, the mask register reads 0x2FF (every implemented source masked, 1 means masked), and irq_out is low.
- R2: A high level on evt_in[i] for an implemented bit i at a rising clock edge sets status bit i. The bit stays set after the event input returns low.
- R3: A write to offset 0x10 clears every status bit whose write-data bit is 1 and leaves bits written with 0 unchanged.
- R4: If an event and a write-1-to-clear hit the same status bit in the same cycle, the bit stays set.
- R5: A write to offset 0x24 clears (unmasks) every mask bit whose write-data bit is 1. Zeros in the write data leave the mask unchanged.
- R6: A write to offset 0x28 sets (masks) every mask bit whose write-data bit is 1. Zeros in the write data leave the mask unchanged.
- R7: irq_out is high exactly when some status bit is set and its mask bit is 0. It follows status and mask changes in the same cycle they become visible on a read.
- R8: Bit 8 and all bits above bit 9 read as 0 in status and mask. An event on bit 8, or ones written there, change nothing.
- R9: Reads of offsets 0x24, 0x28 and any unmapped offset return 0. Writes to the mask offset 0x20 or to an unmapped offset change neither status nor mask.
- R10: A masked source still sets its status bit, and that bit is visible on a read while irq_out stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (8) | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr, combinational |
| evt_in | input | IRQ_W (10) | Event pulses, one per source |
| irq_out | output | 1 | Level interrupt request |

## Verification
The bench goes after the cycle in which an event and a clearing write land on the same bit. A design that lets the clear win would lose that event and read the bit back as 0. It writes zeros and partial patterns to the unmask and mask-set registers. A design that treats these registers as plain stores would rewrite the whole mask instead of touching only the bits written with ones. It reads the write-only and unmapped offsets and writes the mask offset directly. A bank that decodes too loosely would return stored values or let the mask be written. It also fires the unused bit 8 and raises events while their sources are masked. A wrong design would then show a phantom status bit, or assert the interrupt despite the mask.

// File: rtl/irqbank_pkg.sv
package irqbank_pkg;

    localparam int DATA_W_DEF = 32;
    localparam int ADDR_W_DEF = 8;
    localparam int IRQ_W_DEF  = 10;

    // Sources that exist; bit 8 is a hole in the layout
    localparam logic [IRQ_W_DEF-1:0] IMPL_DEF = 10'h2FF;

    localparam logic [ADDR_W_DEF-1:0] OFS_STATUS_DEF  = 8'h10;
    localparam logic [ADDR_W_DEF-1:0] OFS_MASK_DEF    = 8'h20;
    localparam logic [ADDR_W_DEF-1:0] OFS_UNMASK_DEF  = 8'h24;
    localparam logic [ADDR_W_DEF-1:0] OFS_MASKSET_DEF = 8'h28;

    // One-hot register selection produced by the decoder
    typedef struct packed {
        logic sts;
        logic msk;
        logic unm;
        logic mst;
    } regsel_t;

    typedef enum logic [1:0] {
        RSRC_ZERO,
        RSRC_STATUS,
        RSRC_MASK
    } rdsrc_e;

    // Only status and mask are readable; everything else yields zero
    function automatic rdsrc_e pick_read_source(regsel_t s);
        rdsrc_e r;
        r = RSRC_ZERO;
        if (s.sts)      r = RSRC_STATUS;
        else if (s.msk) r = RSRC_MASK;
        else if (s.unm || s.mst) r = RSRC_ZERO;
        return r;
    endfunction

endpackage

// File: rtl/irqbank_decode.sv
module irqbank_decode
    import irqbank_pkg::*;
#(
    parameter int                ADDR_W      = ADDR_W_DEF,
    parameter logic [ADDR_W-1:0] OFS_STATUS  = OFS_STATUS_DEF,
    parameter logic [ADDR_W-1:0] OFS_MASK    = OFS_MASK_DEF,
    parameter logic [ADDR_W-1:0] OFS_UNMASK  = OFS_UNMASK_DEF,
    parameter logic [ADDR_W-1:0] OFS_MASKSET = OFS_MASKSET_DEF
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output regsel_t           rsel,
    output regsel_t           wsel
);

    always_comb begin
        rsel.sts = (addr == OFS_STATUS);
        rsel.msk = (addr == OFS_MASK);
        rsel.unm = (addr == OFS_UNMASK);
        rsel.mst = (addr == OFS_MASKSET);
    end

    always_comb begin
        wsel.sts = wr && rsel.sts;
        wsel.msk = wr && rsel.msk;
        wsel.unm = wr && rsel.unm;
        wsel.mst = wr && rsel.mst;
    end

endmodule

// File: rtl/irqbank_status.sv
module irqbank_status
    import irqbank_pkg::*;
#(
    parameter int               IRQ_W = IRQ_W_DEF,
    parameter logic [IRQ_W-1:0] IMPL  = IMPL_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IRQ_W-1:0] evt,
    input  logic             clr_en,
    input  logic [IRQ_W-1:0] clr_bits,
    output logic [IRQ_W-1:0] q
);

    for (genvar i = 0; i < IRQ_W; i++) begin : g_bit
        if (IMPL[i]) begin : g_live
            logic bit_q;
            always_ff @(posedge clk) begin
                if (rst)
                    bit_q <= 1'b0;
                else if (evt[i])
                    bit_q <= 1'b1;          // a new event beats a clear
                else if (clr_en && clr_bits[i])
                    bit_q <= 1'b0;
            end
            assign q[i] = bit_q;
        end else begin : g_hole
            logic unused_evt;
            assign unused_evt = evt[i] ^ clr_bits[i];
            assign q[i] = 1'b0;
        end
    end

endmodule

// File: rtl/irqbank_mask.sv
module irqbank_mask
    import irqbank_pkg::*;
#(
    parameter int               IRQ_W = IRQ_W_DEF,
    parameter logic [IRQ_W-1:0] IMPL  = IMPL_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             unmask_en,
    input  logic             maskset_en,
    input  logic [IRQ_W-1:0] bits,
    output logic [IRQ_W-1:0] q
);

    for (genvar i = 0; i < IRQ_W; i++) begin : g_bit
        if (IMPL[i]) begin : g_live
            logic bit_q;
            always_ff @(posedge clk) begin
                if (rst)
                    bit_q <= 1'b1;
                else if (maskset_en && bits[i])
                    bit_q <= 1'b1;
                else if (unmask_en && bits[i])
                    bit_q <= 1'b0;
            end
            assign q[i] = bit_q;
        end else begin : g_hole
            logic unused_bit;
            assign unused_bit = bits[i];
            assign q[i] = 1'b0;
        end
    end

endmodule

// File: rtl/irq_regbank.sv
module irq_regbank
    import irqbank_pkg::*;
#(
    parameter int                DATA_W      = DATA_W_DEF,
    parameter int                ADDR_W      = ADDR_W_DEF,
    parameter int                IRQ_W       = IRQ_W_DEF,
    parameter logic [IRQ_W-1:0]  IMPL        = IMPL_DEF,
    parameter logic [ADDR_W-1:0] OFS_STATUS  = OFS_STATUS_DEF,
    parameter logic [ADDR_W-1:0] OFS_MASK    = OFS_MASK_DEF,
    parameter logic [ADDR_W-1:0] OFS_UNMASK  = OFS_UNMASK_DEF,
    parameter logic [ADDR_W-1:0] OFS_MASKSET = OFS_MASKSET_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [IRQ_W-1:0]  evt_in,
    output logic              irq_out
);

    localparam int PAD_W = DATA_W - IRQ_W;

    regsel_t          rsel;
    regsel_t          wsel;
    logic [IRQ_W-1:0] wfield;
    logic [IRQ_W-1:0] status_q;
    logic [IRQ_W-1:0] mask_q;
    logic [PAD_W-1:0] unused_hi;
    logic             unused_mskwr;

    assign wfield       = bus_wdata[IRQ_W-1:0];
    assign unused_hi    = bus_wdata[DATA_W-1:IRQ_W];
    assign unused_mskwr = wsel.msk;   // mask offset is read-only

    irqbank_decode #(
        .ADDR_W     (ADDR_W),
        .OFS_STATUS (OFS_STATUS),
        .OFS_MASK   (OFS_MASK),
        .OFS_UNMASK (OFS_UNMASK),
        .OFS_MASKSET(OFS_MASKSET)
    ) u_decode (
        .addr(bus_addr),
        .wr  (bus_wr),
        .rsel(rsel),
        .wsel(wsel)
    );

    irqbank_status #(
        .IRQ_W(IRQ_W),
        .IMPL (IMPL)
    ) u_status (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt_in),
        .clr_en  (wsel.sts),
        .clr_bits(wfield),
        .q       (status_q)
    );

    irqbank_mask #(
        .IRQ_W(IRQ_W),
        .IMPL (IMPL)
    ) u_mask (
        .clk       (clk),
        .rst       (rst),
        .unmask_en (wsel.unm),
        .maskset_en(wsel.mst),
        .bits      (wfield),
        .q         (mask_q)
    );

    always_comb begin
        unique case (pick_read_source(rsel))
            RSRC_STATUS: bus_rdata = {{PAD_W{1'b0}}, status_q};
            RSRC_MASK:   bus_rdata = {{PAD_W{1'b0}}, mask_q};
            default:     bus_rdata = '0;
        endcase
    end

    assign irq_out = |(status_q & ~mask_q);

endmodule

// File: rtl/irq_regbank_chk.sv
module irq_regbank_chk #(
    parameter int                DATA_W      = 32,
    parameter int                ADDR_W      = 8,
    parameter int                IRQ_W       = 10,
    parameter logic [IRQ_W-1:0]  IMPL        = 10'h2FF,
    parameter logic [ADDR_W-1:0] OFS_STATUS  = 8'h10,
    parameter logic [ADDR_W-1:0] OFS_UNMASK  = 8'h24,
    parameter logic [ADDR_W-1:0] OFS_MASKSET = 8'h28
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [IRQ_W-1:0]  wfield,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [IRQ_W-1:0]  evt_in,
    input logic              irq_out,
    input logic [IRQ_W-1:0]  status_q,
    input logic [IRQ_W-1:0]  mask_q
);

    // High from the second cycle after reset release, so $past never reaches into reset
    logic live_q;
    always_ff @(posedge clk) begin
        if (rst) live_q <= 1'b0;
        else     live_q <= 1'b1;
    end

    logic sts_wr, unm_wr, mst_wr;
    assign sts_wr = bus_wr && (bus_addr == OFS_STATUS);
    assign unm_wr = bus_wr && (bus_addr == OFS_UNMASK);
    assign mst_wr = bus_wr && (bus_addr == OFS_MASKSET);

    p_capture_r2: assert property (@(posedge clk) disable iff (rst)
        live_q |-> ((status_q & $past(evt_in & IMPL)) == $past(evt_in & IMPL)));

    p_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(sts_wr)) |-> ((status_q & $past(wfield & ~evt_in)) == '0));

    p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        (live_q && !$past(sts_wr)) |-> ((status_q & $past(status_q)) == $past(status_q)));

    p_unmask_r5: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(unm_wr)) |-> ((mask_q & $past(wfield)) == '0));

    p_maskset_r6: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(mst_wr)) |-> ((mask_q & $past(wfield & IMPL)) == $past(wfield & IMPL)));

    p_mask_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (live_q && !$past(unm_wr) && !$past(mst_wr)) |-> $stable(mask_q));

    p_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (status_q == '0) |-> !irq_out);

    p_hole_r8: assert property (@(posedge clk) disable iff (rst)
        ((status_q | mask_q) & ~IMPL) == '0);

    p_wo_read_r9: assert property (@(posedge clk) disable iff (rst)
        ((bus_addr == OFS_UNMASK) || (bus_addr == OFS_MASKSET)) |-> (bus_rdata == '0));

endmodule

bind irq_regbank irq_regbank_chk #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .IRQ_W      (IRQ_W),
    .IMPL       (IMPL),
    .OFS_STATUS (OFS_STATUS),
    .OFS_UNMASK (OFS_UNMASK),
    .OFS_MASKSET(OFS_MASKSET)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .wfield   (bus_wdata[IRQ_W-1:0]),
    .bus_rdata(bus_rdata),
    .evt_in   (evt_in),
    .irq_out  (irq_out),
    .status_q (status_q),
    .mask_q   (mask_q)
);

// File: tb/irq_regbank_test.sv
module irq_regbank_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_STS = 8'h10;
    localparam logic [7:0] A_MSK = 8'h20;
    localparam logic [7:0] A_UNM = 8'h24;
    localparam logic [7:0] A_MST = 8'h28;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [9:0]  evt_in = '0;
    logic        irq_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_regbank uut (
        .clk      (clk),
        .rst      (rst),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .evt_in   (evt_in),
        .irq_out  (irq_out)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    // Inputs change on falling edges; results are taken one falling edge later
    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic fire(input logic [9:0] e);
        @(negedge clk);
        evt_in = e;
        @(negedge clk);
        evt_in = '0;
    endtask

    task automatic clean_slate();
        wr_reg(A_STS, 32'h3FF);
        wr_reg(A_MST, 32'h3FF);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd_reg(A_STS, v); check("R1 status", v, 32'h000);
        rd_reg(A_MSK, v); check("R1 mask", v, 32'h2FF);
        check("R1 irq", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_capture_masked();
        logic [31:0] v;
        clean_slate();
        fire(10'h005);
        rd_reg(A_STS, v); check("R2 sticky capture", v, 32'h005);
        check("R10 masked irq low", {31'b0, irq_out}, 32'h0);
        fire(10'h040);
        rd_reg(A_STS, v); check("R10 masked still latches", v, 32'h045);
    endtask

    task automatic t_unmask();
        logic [31:0] v;
        clean_slate();
        fire(10'h001);
        wr_reg(A_UNM, 32'h000);
        rd_reg(A_MSK, v); check("R5 zero write no effect", v, 32'h2FF);
        check("R7 irq low while masked", {31'b0, irq_out}, 32'h0);
        wr_reg(A_UNM, 32'h001);
        rd_reg(A_MSK, v); check("R5 unmask bit0", v, 32'h2FE);
        check("R7 irq high", {31'b0, irq_out}, 32'h1);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        clean_slate();
        wr_reg(A_UNM, 32'h001);
        fire(10'h005);
        wr_reg(A_STS, 32'h004);
        rd_reg(A_STS, v); check("R3 partial clear", v, 32'h001);
        check("R7 irq stays high", {31'b0, irq_out}, 32'h1);
        wr_reg(A_STS, 32'h001);
        rd_reg(A_STS, v); check("R3 full clear", v, 32'h000);
        check("R7 irq drops", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_maskset();
        logic [31:0] v;
        clean_slate();
        wr_reg(A_UNM, 32'h3FF);
        rd_reg(A_MSK, v); check("R5 unmask all", v, 32'h000);
        fire(10'h200);
        check("R7 irq on bit9", {31'b0, irq_out}, 32'h1);
        wr_reg(A_MST, 32'h000);
        rd_reg(A_MSK, v); check("R6 zero write no effect", v, 32'h000);
        wr_reg(A_MST, 32'h200);
        rd_reg(A_MSK, v); check("R6 mask bit9", v, 32'h200);
        check("R7 irq masked off", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_race();
        logic [31:0] v;
        clean_slate();
        fire(10'h00A);
        @(negedge clk);
        bus_addr = A_STS; bus_wdata = 32'h00A; bus_wr = 1'b1; evt_in = 10'h002;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0; evt_in = '0;
        rd_reg(A_STS, v); check("R4 event beats clear", v, 32'h002);
    endtask

    task automatic t_hole();
        logic [31:0] v;
        clean_slate();
        fire(10'h100);
        rd_reg(A_STS, v); check("R8 bit8 event ignored", v, 32'h000);
        wr_reg(A_UNM, 32'hFFFF_FFFF);
        rd_reg(A_MSK, v); check("R8 mask upper bits zero", v, 32'h000);
        check("R8 irq low", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_decode();
        logic [31:0] v;
        clean_slate();
        fire(10'h003);
        rd_reg(A_UNM, v);   check("R9 unmask reads zero", v, 32'h0);
        rd_reg(A_MST, v);   check("R9 maskset reads zero", v, 32'h0);
        rd_reg(8'h14, v);   check("R9 unmapped reads zero", v, 32'h0);
        wr_reg(A_MSK, 32'h000);
        wr_reg(8'h2C, 32'h3FF);
        rd_reg(A_MSK, v);   check("R9 mask write ignored", v, 32'h2FF);
        rd_reg(A_STS, v);   check("R9 status untouched", v, 32'h003);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_capture_masked();
        t_unmask();
        t_clear();
        t_maskset();
        t_race();
        t_hole();
        t_decode();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule